// File: doc/BRIEF.md
# Serial Host Command Port with Program Boot

This block is the slave end of a clocked serial control link. A host frames each transaction with an active-low select. It shifts bits in MSB first on rising edges of a serial clock and commits each finished 24-bit word with a latch pulse. The first word of a transaction is a command. That command carries a 16-bit target address, a read/write direction, a burst length of one to eight words, a soft-reset flag and a program-boot flag. The words that follow it are write data, or boot data for program RAM. For a read, the data flows back out on a serial output. An acknowledge output, high meaning busy, tells the host when it may shift.

For a write, each data word goes to a data-memory port at the command's address plus the word's position in the burst. For a read, the block fetches the burst from the same port into an internal buffer while acknowledge is held high. It then drops acknowledge, and the host clocks the words out. A boot command sends the low 16 bits of each data word to a 1024-word program RAM port, starting at address 0 whatever the command's address field holds. The soft-reset output follows the soft-reset flag of every accepted command.

The controller has nine states:
- IDLE: select is high.
- CMD: waiting for the command word.
- HOLD: a fixed busy window after every command.
- FETCH: one read strobe per burst word.
- FILL: the last fetched word is captured.
- WRDATA: write bursts.
- BOOT: program loading.
- RDOUT: serial read-out.
- DONE: every later word is ignored.

The transitions are:
- select falling: IDLE→CMD.
- command committed: CMD→HOLD.
- hold expired: HOLD→FETCH, HOLD→BOOT or HOLD→WRDATA, chosen by the flags.
- last strobe: FETCH→FILL.
- FILL→RDOUT, unconditionally.
- burst complete: WRDATA→DONE and RDOUT→DONE.
- last program address: BOOT→DONE.
- select high: any state→IDLE.

Top module: `hci_port`

## Requirements
- R1: Command word layout. Bits 23..8 are the address. Bit 6 = 1 selects boot. Bit 5 is the soft-reset flag. Bit 4 = 1 selects read. Bits 2..0 hold the word count minus one. Bits 7 and 3 are ignored. Serial bits are taken MSB first on `sclk` rising edges. A word is committed on a `latch` rising edge only if exactly 24 `sclk` rises occurred since the previous latch pulse or since select fell. Otherwise the latch pulse discards the bits.
- R2: `ack` is low while select is high and in the idle-ready states. It is high for exactly HOLD_CYC cycles after a non-read command is committed.
- R3: In a write burst, data word k (k from 0) produces one `mem_we` cycle with `mem_addr` = address + k (modulo 2^16) and `mem_wdata` = the word. Words beyond the count are ignored.
- R4: `soft_rst` takes the value of bit 5 of each committed command, and keeps it until the next command.
- R5: For a read of N words, `ack` stays high for HOLD_CYC + N + 1 cycles, during which `mem_re` is issued for address + 0 .. address + N−1. `ack` then falls. Each subsequent `sclk` rise advances `sdo` through the buffered words, MSB first, word k being the memory data at address + k. Reads never assert `mem_we`.
- R6: A boot command writes the low 16 bits of each data word to `pram_addr` 0, 1, 2, … and ignores the command's address and count fields. The burst ends after address 3FFh, and later words are ignored.
- R7: Select rising aborts the transaction. Partially shifted bits are dropped with no write, and the next transaction, including a new boot, starts afresh from address 0.
- R8: A data word committed while `ack` is high is discarded.
- R9: After reset `ack`, `sdo`, `soft_rst` and all memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Transaction select, active low |
| sclk | input | 1 | Serial bit clock from host |
| sdi | input | 1 | Serial data in, MSB first |
| latch | input | 1 | Word commit pulse |
| ack | output | 1 | Busy indication, high = host must wait |
| sdo | output | 1 | Serial read data |
| soft_rst | output | 1 | Soft reset to the core |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 24 | Data memory write data |
| mem_rdata | input | 24 | Data memory read data, one cycle after `mem_re` |
| pram_we | output | 1 | Program RAM write strobe |
| pram_addr | output | 10 | Program RAM address |
| pram_wdata | output | 16 | Program RAM write data |

## Verification
The hardest case to reach is a data word that completes while the block is still busy after a command (R8). A host that respects `ack` never produces it, and the default hold window is far shorter than one 24-bit word. The bench therefore builds the block with a hold window of 80 cycles. It then shifts a full data word straight after the command, without waiting for `ack`. That word is checked to leave no write, and the next legal word is checked to land at the base address. A full 1024-word boot with one extra trailing word drives the BOOT→DONE edge at address 3FFh.

// File: rtl/hci_pkg.sv
package hci_pkg;
    localparam int HCI_DW    = 24;
    localparam int HCI_AW    = 16;
    localparam int HCI_PW    = 16;
    localparam int HCI_CNT_W = 3;
    localparam int HCI_MAXW  = 1 << HCI_CNT_W;
    localparam int HCI_B_RD   = 4;
    localparam int HCI_B_SRST = 5;
    localparam int HCI_B_BOOT = 6;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_HOLD, S_FETCH, S_FILL,
        S_WRDATA, S_BOOT, S_RDOUT, S_DONE
    } hci_state_e;

    typedef struct packed {
        logic [HCI_AW-1:0]    addr;
        logic                 boot;
        logic                 srst;
        logic                 rd;
        logic [HCI_CNT_W-1:0] cnt_m1;
    } hci_cmd_t;

    function automatic hci_cmd_t hci_decode(input logic [HCI_DW-1:0] w);
        hci_cmd_t c;
        c.addr   = w[HCI_DW-1 -: HCI_AW];
        c.boot   = w[HCI_B_BOOT];
        c.srst   = w[HCI_B_SRST];
        c.rd     = w[HCI_B_RD];
        c.cnt_m1 = w[HCI_CNT_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/hci_shift_in.sv
module hci_shift_in #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdi,
    input  logic          latch,
    output logic          cs_s,
    output logic          sclk_rise,
    output logic          word_ok,
    output logic [DW-1:0] word
);
    localparam int CW = $clog2(DW + 2);

    logic          sclk_q, sclk_qq, sdi_q, lp_q, lp_qq;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sreg;

    assign sclk_rise = sclk_q & ~sclk_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s    <= 1'b1;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            sdi_q   <= 1'b0;
            lp_q    <= 1'b0;
            lp_qq   <= 1'b0;
            cnt     <= '0;
            sreg    <= '0;
            word    <= '0;
            word_ok <= 1'b0;
        end else begin
            cs_s    <= cs_n;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            sdi_q   <= sdi;
            lp_q    <= latch;
            lp_qq   <= lp_q;
            word_ok <= 1'b0;
            if (cs_s) begin
                cnt <= '0;
            end else if (lp_q && !lp_qq) begin
                word_ok <= (cnt == CW'(DW));
                word    <= sreg;
                cnt     <= '0;
            end else if (sclk_rise) begin
                sreg <= {sreg[DW-2:0], sdi_q};
                if (cnt != CW'(DW + 1)) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hci_rdbuf.sv
module hci_rdbuf #(
    parameter int DW    = 24,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    input  logic [$clog2(DW)-1:0]    rbit,
    output logic                     bit_out
);
    localparam int BW = $clog2(DW);

    logic [DW-1:0] store [DEPTH];
    logic [BW-1:0] sel;

    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    assign sel     = BW'(DW - 1) - rbit;
    assign bit_out = store[ridx][sel];
endmodule

// File: rtl/hci_port.sv
module hci_port
    import hci_pkg::*;
#(
    parameter int HOLD_CYC   = 16,
    parameter int PRAM_DEPTH = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          sclk,
    input  logic                          sdi,
    input  logic                          latch,
    output logic                          ack,
    output logic                          sdo,
    output logic                          soft_rst,
    output logic                          mem_re,
    output logic                          mem_we,
    output logic [HCI_AW-1:0]             mem_addr,
    output logic [HCI_DW-1:0]             mem_wdata,
    input  logic [HCI_DW-1:0]             mem_rdata,
    output logic                          pram_we,
    output logic [$clog2(PRAM_DEPTH)-1:0] pram_addr,
    output logic [HCI_PW-1:0]             pram_wdata
);
    localparam int PAW = $clog2(PRAM_DEPTH);
    localparam int HCW = $clog2(HOLD_CYC + 1);
    localparam int BW  = $clog2(HCI_DW);

    hci_state_e            st, st_nx;
    hci_cmd_t              cmd_q, cmd_in;
    logic                  cs_s, sclk_rise, word_ok, buf_bit, fill_we;
    logic [HCI_DW-1:0]     word;
    logic [HCW-1:0]        hold_ctr;
    logic [HCI_CNT_W-1:0]  wk, fill_idx;
    logic [PAW-1:0]        baddr;
    logic [BW-1:0]         obit;

    hci_shift_in #(.DW(HCI_DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .latch(latch), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .word_ok(word_ok), .word(word)
    );

    hci_rdbuf #(.DW(HCI_DW), .DEPTH(HCI_MAXW)) u_rdbuf (
        .clk(clk), .we(fill_we), .widx(fill_idx), .wdata(mem_rdata),
        .ridx(wk), .rbit(obit), .bit_out(buf_bit)
    );

    assign cmd_in = hci_decode(word);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        if (cs_s) begin
            st_nx = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE:   st_nx = S_CMD;
                S_CMD:    if (word_ok) st_nx = S_HOLD;
                S_HOLD:   if (hold_ctr == HCW'(HOLD_CYC - 1))
                              st_nx = cmd_q.rd   ? S_FETCH :
                                      cmd_q.boot ? S_BOOT  : S_WRDATA;
                S_FETCH:  if (wk == cmd_q.cnt_m1) st_nx = S_FILL;
                S_FILL:   st_nx = S_RDOUT;
                S_WRDATA: if (word_ok && wk == cmd_q.cnt_m1) st_nx = S_DONE;
                S_BOOT:   if (word_ok && baddr == PAW'(PRAM_DEPTH - 1)) st_nx = S_DONE;
                S_RDOUT:  if (sclk_rise && obit == BW'(HCI_DW - 1) && wk == cmd_q.cnt_m1)
                              st_nx = S_DONE;
                S_DONE:   st_nx = S_DONE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ack        = (st == S_HOLD) || (st == S_FETCH) || (st == S_FILL);
        mem_re     = (st == S_FETCH);
        mem_we     = (st == S_WRDATA) && word_ok;
        mem_addr   = cmd_q.addr + HCI_AW'(wk);
        mem_wdata  = word;
        pram_we    = (st == S_BOOT) && word_ok;
        pram_addr  = baddr;
        pram_wdata = word[HCI_PW-1:0];
        sdo        = (st == S_RDOUT) && buf_bit;
    end

    // counters and command register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            soft_rst <= 1'b0;
            hold_ctr <= '0;
            wk       <= '0;
            baddr    <= '0;
            obit     <= '0;
            fill_we  <= 1'b0;
            fill_idx <= '0;
        end else begin
            fill_we  <= (st == S_FETCH);
            fill_idx <= wk;
            case (st)
                S_IDLE: begin
                    hold_ctr <= '0;
                    wk       <= '0;
                    baddr    <= '0;
                    obit     <= '0;
                end
                S_CMD: if (word_ok) begin
                    cmd_q    <= cmd_in;
                    soft_rst <= cmd_in.srst;
                end
                S_HOLD:   hold_ctr <= hold_ctr + 1'b1;
                S_FETCH:  wk <= (wk == cmd_q.cnt_m1) ? '0 : wk + 1'b1;
                S_WRDATA: if (word_ok) wk <= wk + 1'b1;
                S_BOOT:   if (word_ok) baddr <= baddr + 1'b1;
                S_RDOUT: if (sclk_rise) begin
                    if (obit == BW'(HCI_DW - 1)) begin
                        obit <= '0;
                        wk   <= wk + 1'b1;
                    end else begin
                        obit <= obit + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hci_port_chk.sv
module hci_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic ack,
    input logic mem_re,
    input logic mem_we,
    input logic pram_we,
    input logic soft_rst
);
    // R2: a select held high brings the port back to ready
    a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) |-> !ack);

    // R5: read strobes only occur inside the busy window
    a_r5_fetch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ack);

    // R8: no memory write while busy
    a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !ack);

    // R3: a single memory strobe at a time
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R6: boot writes never touch the data port
    a_r6_boot_only_pram: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we |-> !mem_we && !mem_re && !ack);

    // R4: soft reset only moves when a command is taken
    a_r4_srst_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ack && $past(!ack) && !$rose(ack) |-> $stable(soft_rst) || $past(!ack, 2) == 1'b0
        || $stable(soft_rst));
endmodule

bind hci_port hci_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ack(ack), .mem_re(mem_re),
    .mem_we(mem_we), .pram_we(pram_we), .soft_rst(soft_rst)
);

// File: tb/hci_port_tb_top.sv
module hci_port_tb_top;
    localparam int HOLD = 80;
    localparam int PD   = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, cs_n, sclk, sdi, latch;
    logic        ack, sdo, soft_rst, mem_re, mem_we, pram_we;
    logic [15:0] mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic [9:0]  pram_addr;
    logic [15:0] pram_wdata;

    hci_port #(.HOLD_CYC(HOLD), .PRAM_DEPTH(PD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .latch(latch), .ack(ack), .sdo(sdo), .soft_rst(soft_rst),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pram_we(pram_we),
        .pram_addr(pram_addr), .pram_wdata(pram_wdata)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [23:0] pat(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, a};
    endfunction

    function automatic logic [15:0] bootval(input logic [9:0] a);
        return 16'({6'd0, a} * 16'd37 + 16'd5);
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) if (mem_re) mem_rdata <= pat(mem_addr);

    logic [15:0] wa [64];
    logic [23:0] wd [64];
    int wn = 0;
    always @(posedge clk) if (mem_we) begin
        wa[wn % 64] <= mem_addr;
        wd[wn % 64] <= mem_wdata;
        wn <= wn + 1;
    end

    int pn = 0;
    int perr = 0;
    logic [9:0] plast = '0;
    always @(posedge clk) if (pram_we) begin
        if (pram_wdata != bootval(pram_addr) ||
            (pn != 0 && pram_addr != 10'd0 && pram_addr != plast + 10'd1))
            perr <= perr + 1;
        plast <= pram_addr;
        pn <= pn + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sdi = b; sclk = 1'b1; tick(); sclk = 1'b0; tick();
    endtask

    task automatic sbits(input logic [23:0] w, input int n);
        for (int i = 23; i > 23 - n; i--) sbit(w[i]);
    endtask

    task automatic pulse_latch;
        latch = 1'b1; tick(); latch = 1'b0;
    endtask

    task automatic wait_ready;
        for (int t = 0; t < 5000 && ack; t++) tick();
    endtask

    task automatic put_word(input logic [23:0] w);
        sbits(w, 24); pulse_latch(); tick(3);
    endtask

    task automatic begin_txn;
        cs_n = 1'b0; tick(2); wait_ready();
    endtask

    task automatic end_txn;
        cs_n = 1'b1; tick(4);
    endtask

    task automatic send_cmd(input logic [23:0] c, output int hi);
        sbits(c, 24); pulse_latch();
        hi = 0;
        for (int t = 0; t < 5000; t++) begin
            if (ack) hi++;
            else if (hi > 0) break;
            tick();
        end
    endtask

    task automatic get_word(output logic [23:0] w);
        w = '0;
        for (int i = 0; i < 24; i++) begin
            w = {w[22:0], sdo};
            sclk = 1'b1; tick(); sclk = 1'b0; tick();
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int hi, w0, p0;
        logic [23:0] rw;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; latch = 1'b0;
        tick(5);
        chk(!ack && !sdo && !soft_rst && !mem_we && !mem_re && !pram_we, "R9 reset outputs",
            {ack, sdo, soft_rst, mem_we, mem_re, pram_we}, 0);
        rst_n = 1'b1; tick(2);
        chk(!ack, "R2 ready when idle", ack, 0);

        // R1 R2 R3: three-word write
        begin_txn();
        send_cmd(24'h123002, hi);
        chk(hi == HOLD, "R2 hold window", hi, HOLD);
        w0 = wn;
        for (int k = 0; k < 3; k++) put_word(24'hA00000 + 24'(k * 'h1111));
        end_txn();
        chk(wn - w0 == 3, "R3 write count", wn - w0, 3);
        for (int k = 0; k < 3; k++) begin
            chk(wa[(w0 + k) % 64] == 16'h1230 + 16'(k), "R3 write address", wa[(w0 + k) % 64], 16'h1230 + k);
            chk(wd[(w0 + k) % 64] == 24'hA00000 + 24'(k * 'h1111), "R1 write data MSB first",
                wd[(w0 + k) % 64], 24'hA00000 + k * 'h1111);
        end

        // R1 R3: bits 7 and 3 ignored, 8-word burst plus one extra word
        begin_txn();
        send_cmd(24'h01008F, hi);
        w0 = wn;
        for (int k = 0; k < 9; k++) put_word(24'h0B0000 + 24'(k));
        end_txn();
        chk(wn - w0 == 8, "R3 burst of eight, extra ignored", wn - w0, 8);
        chk(wa[(w0 + 7) % 64] == 16'h0107, "R3 last address", wa[(w0 + 7) % 64], 16'h0107);
        chk(soft_rst == 1'b0, "R4 flag clear", soft_rst, 0);

        // R1 short word discarded, R7 partial word at select rise dropped
        begin_txn();
        send_cmd(24'h200003, hi);
        w0 = wn;
        sbits(24'hFFFFFF, 20); pulse_latch(); tick(3);
        put_word(24'h00C0DE);
        sbits(24'h777777, 10);
        end_txn();
        chk(wn - w0 == 1, "R1 R7 only the full word written", wn - w0, 1);
        chk(wa[w0 % 64] == 16'h2000 && wd[w0 % 64] == 24'h00C0DE, "R1 short latch discarded",
            wd[w0 % 64], 24'h00C0DE);
        begin_txn();
        send_cmd(24'h300000, hi);
        w0 = wn;
        put_word(24'h135790);
        end_txn();
        chk(wn - w0 == 1 && wa[w0 % 64] == 16'h3000 && wd[w0 % 64] == 24'h135790,
            "R7 fresh transaction after abort", wd[w0 % 64], 24'h135790);

        // R8: word committed while busy
        begin_txn();
        w0 = wn;
        sbits(24'h400001, 24); pulse_latch(); tick(2);
        put_word(24'hBAD000);
        chk(ack == 1'b1, "R8 word landed in busy window", ack, 1);
        wait_ready();
        put_word(24'h600D00);
        end_txn();
        chk(wn - w0 == 1 && wa[w0 % 64] == 16'h4000 && wd[w0 % 64] == 24'h600D00,
            "R8 busy word discarded", wd[w0 % 64], 24'h600D00);

        // R5: single-word read
        begin_txn();
        w0 = wn;
        send_cmd(24'h500510, hi);
        chk(hi == HOLD + 2, "R5 busy window N=1", hi, HOLD + 2);
        get_word(rw);
        chk(rw == pat(16'h5005), "R5 read word", rw, pat(16'h5005));
        end_txn();

        // R5: eight-word read with address wrap
        begin_txn();
        send_cmd(24'hFFFC17, hi);
        chk(hi == HOLD + 9, "R5 busy window N=8", hi, HOLD + 9);
        for (int k = 0; k < 8; k++) begin
            get_word(rw);
            chk(rw == pat(16'hFFFC + 16'(k)), "R5 burst read word", rw, pat(16'hFFFC + 16'(k)));
        end
        end_txn();
        chk(wn == w0, "R5 reads do not write", wn, w0);

        // R4: soft reset on and off
        begin_txn();
        send_cmd(24'h000020, hi);
        end_txn();
        chk(soft_rst == 1'b1 && hi == HOLD, "R4 soft reset asserted", soft_rst, 1);
        begin_txn();
        send_cmd(24'h000000, hi);
        end_txn();
        chk(soft_rst == 1'b0, "R4 soft reset released", soft_rst, 0);

        // R6 R7: aborted boot
        p0 = pn;
        begin_txn();
        send_cmd(24'h000060, hi);
        for (int k = 0; k < 5; k++) put_word({8'hC3, bootval(10'(k))});
        end_txn();
        chk(pn - p0 == 5 && plast == 10'd4, "R7 boot aborted after five", pn - p0, 5);

        // R6: full boot, address and count fields ignored, trailing word ignored
        p0 = pn;
        w0 = wn;
        begin_txn();
        send_cmd(24'hABCD63, hi);
        for (int k = 0; k <= PD; k++) put_word({8'hC3, bootval(10'(k))});
        end_txn();
        chk(pn - p0 == PD, "R6 boot word count", pn - p0, PD);
        chk(plast == 10'h3FF, "R6 last boot address", plast, 10'h3FF);
        chk(perr == 0, "R6 boot address order and data", perr, 0);
        chk(wn == w0 && soft_rst == 1'b1, "R6 boot uses program port only", wn - w0, 0);

        begin_txn();
        send_cmd(24'h000000, hi);
        end_txn();
        chk(soft_rst == 1'b0 && !ack && !sdo, "R4 release after boot", soft_rst, 0);

        summary();
    end
endmodule